// File: doc/BRIEF.md
# Quad-Data-Rate Burst SRAM Model

This block is a synthesizable, reduced-depth model of a synchronous SRAM with separate read and write data ports, a single shared address bus and four-word bursts. It runs from one clock at twice the rate of the memory clock. A free-running slot counter splits each pair of memory-clock periods into four half-period slots: read-command rising edge, read-command falling edge, write-command rising edge and write-command falling edge. The read command is taken from the address bus in the first slot and the write command in the third. Every data transfer on either port occupies one slot, so a burst of four words takes two memory-clock periods.

Write beats are collected in a staging buffer and committed to the array as one four-word write in the write-command slot that follows the last beat. Each read takes a coherent snapshot of its four words in the write-command slot of its own frame. The snapshot merges the staged write lane by lane, so a read always sees every write issued before it and none issued after it. A mode input picks the read latency: either one memory-clock period (two slots) or the extended latency of two and a half periods (five slots). A valid flag marks the four output beats.

State machines and transitions: the slot FSM cycles `SLOT_RD_K -> SLOT_RD_KB -> SLOT_WR_K -> SLOT_WR_KB -> SLOT_RD_K`. The write stage moves `WST_IDLE -> WST_B1` on an accepted write command, then `WST_B1 -> WST_B2 -> WST_B3 -> WST_FULL`. From `WST_FULL` it commits and goes to `WST_B1` if a new write is accepted, or to `WST_IDLE` if not. The read command holder goes to `RCS_HELD` on an accepted read, stays in `RCS_EMPTY` on a deselected read slot, and returns to `RCS_EMPTY` once the snapshot is taken. The output sequencer enters `OST_RUN` on a burst launch and returns to `OST_IDLE` after the fourth beat.

Top module: `qdrb_sram`

## Requirements
- R1: After reset `rvalid` is 0, `rdata` is 0 and every word of the array reads back as zero.
- R2: Clock edge 0 is the first edge after reset is released. The slots repeat every four edges in the order read-K, read-K#, write-K, write-K#. `rd_sel_n` and `addr` are sampled as a read command only at edges 4f. `wr_sel_n` and `addr` are sampled as a write command only at edges 4f+2. The select inputs have no effect at any other edge.
- R3: A write command accepted at edge 4f+2 takes `wdata`/`wbe_n` at edges 4f+2, 4f+3, 4f+4 and 4f+5. Beat k is stored in word `addr*4+k`, and distinct addresses never alias, including the top address.
- R4: `wbe_n[j]` = 0 writes lane j (`wdata[j*LANE_W +: LANE_W]`) of the beat. `wbe_n[j]` = 1 leaves that lane of the stored word unchanged.
- R5: With `lat_ext` = 0 at the read command edge E, word k of the burst is on `rdata` after edge E+2+k.
- R6: With `lat_ext` = 1 at the read command edge E, word k of the burst is on `rdata` after edge E+5+k.
- R7: `rvalid` is 1 after exactly the four edges that carry a burst's beats and 0 after every other edge.
- R8: A deselected read slot issues no burst: `rvalid` stays 0 and `rdata` holds its last value. A deselected write slot changes no stored word, and write data seen while no write burst is open is ignored.
- R9: A read returns the data written by every write command issued at an earlier edge, including a write whose beats have not yet been committed. A write issued in the same frame after the read is not visible to that read.
- R10: Read commands in consecutive frames give an unbroken stream of valid beats in either latency mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each edge is one half-period slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Shared burst address (read in slot 0, write in slot 2) |
| rd_sel_n | input | 1 | Active-low read port select |
| wr_sel_n | input | 1 | Active-low write port select |
| wdata | input | LANE_W*LANES | Write data beat |
| wbe_n | input | LANES | Active-low per-lane write enable for the current beat |
| lat_ext | input | 1 | 1 selects the extended read latency, 0 the one-period latency |
| rdata | output | LANE_W*LANES | Read data beat |
| rvalid | output | 1 | High while `rdata` carries a burst beat |

## Verification
The hardest case to reach is a read whose snapshot lands on the same edge as the commit of the write before it. This happens only when a write to an address is issued in one frame and a read of that address in the very next frame. The stimulus builds exactly that pattern, with full and partial lane enables, so the forwarded lanes and the array lanes must both be correct. It also issues a read and a write to one address in the same frame, to show that the later write stays hidden. Select inputs are held low in the slots where they must be ignored, and junk data is driven while no write burst is open, so a wrong slot decode corrupts results that can be seen at the ports.

// File: rtl/qdrb_pkg.sv
package qdrb_pkg;
    localparam int BEATS   = 4;
    localparam int BEAT_W  = 2;
    // extra slots between snapshot and first beat in extended latency mode
    localparam int EXT_GAP = 3;

    typedef enum logic [1:0] {
        SLOT_RD_K  = 2'd0,
        SLOT_RD_KB = 2'd1,
        SLOT_WR_K  = 2'd2,
        SLOT_WR_KB = 2'd3
    } slot_e;

    typedef enum logic [2:0] {
        WST_IDLE = 3'd0,
        WST_B1   = 3'd1,
        WST_B2   = 3'd2,
        WST_B3   = 3'd3,
        WST_FULL = 3'd4
    } wst_e;

    typedef enum logic {
        RCS_EMPTY = 1'b0,
        RCS_HELD  = 1'b1
    } rcs_e;

    typedef enum logic {
        OST_IDLE = 1'b0,
        OST_RUN  = 1'b1
    } ost_e;
endpackage

// File: rtl/qdrb_frame_fsm.sv
module qdrb_frame_fsm
    import qdrb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic rd_slot,
    output logic wr_slot
);
    slot_e slot, slot_nxt;

    always_comb begin
        slot_nxt = slot;
        unique case (slot)
            SLOT_RD_K:  slot_nxt = SLOT_RD_KB;
            SLOT_RD_KB: slot_nxt = SLOT_WR_K;
            SLOT_WR_K:  slot_nxt = SLOT_WR_KB;
            SLOT_WR_KB: slot_nxt = SLOT_RD_K;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot <= SLOT_RD_K;
        else        slot <= slot_nxt;
    end

    always_comb begin
        rd_slot = (slot == SLOT_RD_K);
        wr_slot = (slot == SLOT_WR_K);
    end

    // write command slot always comes two slots after a read command slot
    assert_slot_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_slot |-> $past(rd_slot, 2));
endmodule

// File: rtl/qdrb_write_stage.sv
module qdrb_write_stage
    import qdrb_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LW    = 9,
    parameter int LANES = 2,
    parameter int DW    = LW * LANES
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_slot,
    input  logic                              wr_sel_n,
    input  logic [AW-1:0]                     addr,
    input  logic [DW-1:0]                     wdata,
    input  logic [LANES-1:0]                  wbe_n,
    output logic                              commit,
    output logic [AW-1:0]                     cm_addr,
    output logic [BEATS-1:0][DW-1:0]          cm_data,
    output logic [BEATS-1:0][LANES-1:0]       cm_we
);
    wst_e st, st_nxt;
    logic start;
    logic take;
    logic [BEAT_W-1:0] beat_idx;

    assign start = wr_slot && !wr_sel_n;

    always_comb begin
        st_nxt   = st;
        take     = 1'b0;
        beat_idx = '0;
        unique case (st)
            WST_IDLE: if (start) begin
                st_nxt = WST_B1; take = 1'b1; beat_idx = 2'd0;
            end
            WST_B1: begin st_nxt = WST_B2;   take = 1'b1; beat_idx = 2'd1; end
            WST_B2: begin st_nxt = WST_B3;   take = 1'b1; beat_idx = 2'd2; end
            WST_B3: begin st_nxt = WST_FULL; take = 1'b1; beat_idx = 2'd3; end
            WST_FULL: begin
                st_nxt = start ? WST_B1 : WST_IDLE;
                take   = start;
            end
            default: st_nxt = WST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WST_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_addr <= '0;
            cm_data <= '0;
            cm_we   <= '0;
        end else if (take) begin
            if (start) cm_addr <= addr;
            cm_data[beat_idx] <= wdata;
            cm_we[beat_idx]   <= ~wbe_n;
        end
    end

    assign commit = (st == WST_FULL);

    // the staged burst is written to the array only in a write command slot
    assert_commit_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> wr_slot);
endmodule

// File: rtl/qdrb_array.sv
module qdrb_array
    import qdrb_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LW    = 9,
    parameter int LANES = 2,
    parameter int DW    = LW * LANES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_en,
    input  logic [AW-1:0]                 we_addr,
    input  logic [BEATS-1:0][DW-1:0]      we_data,
    input  logic [BEATS-1:0][LANES-1:0]   we_lane,
    input  logic [AW-1:0]                 rd_addr,
    output logic [BEATS-1:0][DW-1:0]      rd_words
);
    localparam int WORDS = (1 << AW) * BEATS;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (we_en) begin
            for (int b = 0; b < BEATS; b++) begin
                for (int j = 0; j < LANES; j++) begin
                    if (we_lane[b][j])
                        mem[{we_addr, BEAT_W'(b)}][j*LW +: LW] <= we_data[b][j*LW +: LW];
                end
            end
        end
    end

    for (genvar g = 0; g < BEATS; g++) begin : g_rport
        assign rd_words[g] = mem[{rd_addr, BEAT_W'(g)}];
    end
endmodule

// File: rtl/qdrb_read_path.sv
module qdrb_read_path
    import qdrb_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LW    = 9,
    parameter int LANES = 2,
    parameter int DW    = LW * LANES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_slot,
    input  logic                          wr_slot,
    input  logic                          rd_sel_n,
    input  logic [AW-1:0]                 addr,
    input  logic                          lat_ext,
    input  logic [BEATS-1:0][DW-1:0]      arr_words,
    input  logic                          fwd_valid,
    input  logic [AW-1:0]                 fwd_addr,
    input  logic [BEATS-1:0][DW-1:0]      fwd_data,
    input  logic [BEATS-1:0][LANES-1:0]   fwd_we,
    output logic [AW-1:0]                 rc_addr,
    output logic [DW-1:0]                 rdata,
    output logic                          rvalid
);
    rcs_e rcs;
    logic rc_ext;
    logic snap;
    logic fwd_hit;
    logic [BEATS-1:0][DW-1:0] merged;
    logic [BEATS-1:0][DW-1:0] sbuf [2];
    logic wsel;
    logic [EXT_GAP-1:0] dly_v;
    logic dly_idx [EXT_GAP];
    logic launch_leg, launch_ext;
    ost_e ost, ost_nxt;
    logic [BEAT_W-1:0] ocnt, ocnt_nxt;
    logic oidx, oidx_nxt;

    // read command holder
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcs     <= RCS_EMPTY;
            rc_addr <= '0;
            rc_ext  <= 1'b0;
        end else if (rd_slot) begin
            rcs <= rd_sel_n ? RCS_EMPTY : RCS_HELD;
            if (!rd_sel_n) begin
                rc_addr <= addr;
                rc_ext  <= lat_ext;
            end
        end else if (snap) begin
            rcs <= RCS_EMPTY;
        end
    end

    assign snap    = wr_slot && (rcs == RCS_HELD);
    assign fwd_hit = fwd_valid && (fwd_addr == rc_addr);

    // lane-wise merge of the staged write over the array words
    for (genvar g = 0; g < BEATS; g++) begin : g_beat
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            assign merged[g][j*LW +: LW] = (fwd_hit && fwd_we[g][j]) ?
                fwd_data[g][j*LW +: LW] : arr_words[g][j*LW +: LW];
        end
    end

    // snapshot buffers and extended-latency delay line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sbuf[0] <= '0;
            sbuf[1] <= '0;
            wsel    <= 1'b0;
            dly_v   <= '0;
            for (int i = 0; i < EXT_GAP; i++) dly_idx[i] <= 1'b0;
        end else begin
            if (snap) begin
                sbuf[wsel] <= merged;
                wsel       <= ~wsel;
            end
            dly_v      <= {dly_v[EXT_GAP-2:0], snap && rc_ext};
            dly_idx[0] <= wsel;
            for (int i = 1; i < EXT_GAP; i++) dly_idx[i] <= dly_idx[i-1];
        end
    end

    assign launch_leg = snap && !rc_ext;
    assign launch_ext = dly_v[EXT_GAP-1];

    // output sequencer: next state
    always_comb begin
        ost_nxt  = ost;
        ocnt_nxt = ocnt;
        oidx_nxt = oidx;
        if (launch_leg) begin
            ost_nxt = OST_RUN; ocnt_nxt = 2'd1; oidx_nxt = wsel;
        end else if (launch_ext) begin
            ost_nxt = OST_RUN; ocnt_nxt = 2'd1; oidx_nxt = dly_idx[EXT_GAP-1];
        end else begin
            unique case (ost)
                OST_IDLE: ost_nxt = OST_IDLE;
                OST_RUN: begin
                    ocnt_nxt = ocnt + 2'd1;
                    if (ocnt == BEAT_W'(BEATS - 1)) ost_nxt = OST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ost  <= OST_IDLE;
            ocnt <= '0;
            oidx <= 1'b0;
        end else begin
            ost  <= ost_nxt;
            ocnt <= ocnt_nxt;
            oidx <= oidx_nxt;
        end
    end

    // output sequencer: registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (launch_leg) begin
            rdata  <= merged[0];
            rvalid <= 1'b1;
        end else if (launch_ext) begin
            rdata  <= sbuf[dly_idx[EXT_GAP-1]][0];
            rvalid <= 1'b1;
        end else if (ost == OST_RUN) begin
            rdata  <= sbuf[oidx][ocnt];
            rvalid <= 1'b1;
        end else begin
            rvalid <= 1'b0;
        end
    end

    assert_leg_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_leg |-> $past(rd_slot && !rd_sel_n, 2));

    assert_ext_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        launch_ext |-> $past(rd_slot && !rd_sel_n, 5));

    assert_four_beats_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rvalid) |-> $past(rvalid, 4));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> $stable(rdata));
endmodule

// File: rtl/qdrb_sram.sv
module qdrb_sram
    import qdrb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       rd_sel_n,
    input  logic                       wr_sel_n,
    input  logic [LANE_W*LANES-1:0]    wdata,
    input  logic [LANES-1:0]           wbe_n,
    input  logic                       lat_ext,
    output logic [LANE_W*LANES-1:0]    rdata,
    output logic                       rvalid
);
    localparam int DATA_W = LANE_W * LANES;

    logic rd_slot, wr_slot;
    logic commit;
    logic [ADDR_W-1:0] cm_addr, rc_addr;
    logic [BEATS-1:0][DATA_W-1:0] cm_data, arr_words;
    logic [BEATS-1:0][LANES-1:0] cm_we;

    qdrb_frame_fsm u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_slot (rd_slot),
        .wr_slot (wr_slot)
    );

    qdrb_write_stage #(.AW(ADDR_W), .LW(LANE_W), .LANES(LANES), .DW(DATA_W)) u_wstage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_slot  (wr_slot),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .wdata    (wdata),
        .wbe_n    (wbe_n),
        .commit   (commit),
        .cm_addr  (cm_addr),
        .cm_data  (cm_data),
        .cm_we    (cm_we)
    );

    qdrb_array #(.AW(ADDR_W), .LW(LANE_W), .LANES(LANES), .DW(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_en    (commit),
        .we_addr  (cm_addr),
        .we_data  (cm_data),
        .we_lane  (cm_we),
        .rd_addr  (rc_addr),
        .rd_words (arr_words)
    );

    qdrb_read_path #(.AW(ADDR_W), .LW(LANE_W), .LANES(LANES), .DW(DATA_W)) u_rpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_slot   (rd_slot),
        .wr_slot   (wr_slot),
        .rd_sel_n  (rd_sel_n),
        .addr      (addr),
        .lat_ext   (lat_ext),
        .arr_words (arr_words),
        .fwd_valid (commit),
        .fwd_addr  (cm_addr),
        .fwd_data  (cm_data),
        .fwd_we    (cm_we),
        .rc_addr   (rc_addr),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );
endmodule

// File: tb/sim_qdrb_sram.sv
module sim_qdrb_sram;
    localparam int AW = 4;
    localparam int LW = 9;
    localparam int LANES = 2;
    localparam int DW = LW * LANES;
    localparam int WORDS = (1 << AW) * 4;
    localparam int MAXE = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic rd_sel_n = 1'b1;
    logic wr_sel_n = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic [LANES-1:0] wbe_n = '1;
    logic lat_ext = 1'b0;
    logic [DW-1:0] rdata;
    logic rvalid;

    always #2 clk = ~clk;  // 250 MHz

    qdrb_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .wdata(wdata), .wbe_n(wbe_n), .lat_ext(lat_ext), .rdata(rdata), .rvalid(rvalid)
    );

    int n_chk = 0;
    int n_bad = 0;
    int ecount = 0;
    int checked = 0;
    bit done = 0;
    logic          obs_v [MAXE];
    logic [DW-1:0] obs_d [MAXE];
    logic          exp_v [MAXE];
    logic [DW-1:0] exp_d [MAXE];
    logic [DW-1:0] mdl [WORDS];
    logic [DW-1:0] last_d = '0;
    logic [DW-1:0] carry_d [2];
    logic [LANES-1:0] carry_b [2];
    logic [DW-1:0] wd [4];
    logic [LANES-1:0] wb [4];

    task automatic drive_edge(input logic [AW-1:0] a, input logic rs, input logic ws,
                              input logic [DW-1:0] d, input logic [LANES-1:0] be);
        addr = a; rd_sel_n = rs; wr_sel_n = ws; wdata = d; wbe_n = be;
        @(posedge clk);
        #1;
        obs_v[ecount] = rvalid;
        obs_d[ecount] = rdata;
        ecount++;
    endtask

    // one frame: read command slot, idle slot, write command slot, idle slot
    task automatic frame(input bit rd, input logic [AW-1:0] ra, input bit wr, input logic [AW-1:0] wa);
        int f;
        f = ecount / 4;
        if (rd) begin
            for (int k = 0; k < 4; k++) begin
                int e;
                e = lat_ext ? 4*f + 5 + k : 4*f + 2 + k;
                exp_v[e] = 1'b1;
                exp_d[e] = mdl[ra*4 + k];
            end
        end
        if (wr) begin
            for (int k = 0; k < 4; k++)
                for (int j = 0; j < LANES; j++)
                    if (!wb[k][j]) mdl[wa*4 + k][j*LW +: LW] = wd[k][j*LW +: LW];
        end
        // selects held low in slots where they must be ignored (R2)
        drive_edge(ra, !rd, 1'b0, carry_d[0], carry_b[0]);
        drive_edge(~ra, 1'b0, 1'b0, carry_d[1], carry_b[1]);
        drive_edge(wa, 1'b0, !wr, wd[0], wb[0]);
        drive_edge(~wa, 1'b0, 1'b0, wd[1], wb[1]);
        carry_d[0] = wd[2]; carry_b[0] = wb[2];
        carry_d[1] = wd[3]; carry_b[1] = wb[3];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) frame(1'b0, '0, 1'b0, '0);
    endtask

    task automatic set_wd(input logic [DW-1:0] base, input logic [LANES-1:0] b0,
                          input logic [LANES-1:0] b1, input logic [LANES-1:0] b2,
                          input logic [LANES-1:0] b3);
        for (int k = 0; k < 4; k++) wd[k] = base + DW'(k * 'h1111);
        wb[0] = b0; wb[1] = b1; wb[2] = b2; wb[3] = b3;
    endtask

    task automatic check_upto(input string tag);
        for (int e = checked; e < ecount; e++) begin
            logic [DW-1:0] want;
            want = exp_v[e] ? exp_d[e] : last_d;
            n_chk++;
            if (obs_v[e] !== exp_v[e] || obs_d[e] !== want) begin
                n_bad++;
                $display("FAIL %s edge %0d: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                         tag, e, obs_v[e], obs_d[e], exp_v[e], want);
            end
            if (exp_v[e]) last_d = exp_d[e];
        end
        checked = ecount;
    endtask

    task automatic t_reset;
        n_chk++;
        if (rvalid !== 1'b0) begin
            n_bad++; $display("FAIL R1 reset rvalid: actual=%0b expected=0", rvalid);
        end
        n_chk++;
        if (rdata !== '0) begin
            n_bad++; $display("FAIL R1 reset rdata: actual=%h expected=0", rdata);
        end
    endtask

    task automatic t_unwritten;  // R1, R2, R5
        set_wd(18'h3_0F0F, 2'b00, 2'b00, 2'b00, 2'b00);
        frame(1'b1, 4'd3, 1'b0, 4'd3);
        idle(2);
        check_upto("R1/R2/R5 unwritten read");
    endtask

    task automatic t_forward;  // R3, R9
        set_wd(18'h0_A101, 2'b00, 2'b00, 2'b00, 2'b00);
        frame(1'b0, 4'd5, 1'b1, 4'd5);
        frame(1'b1, 4'd5, 1'b0, 4'd5);
        idle(2);
        frame(1'b1, 4'd5, 1'b0, 4'd0);
        idle(2);
        check_upto("R3/R9 forwarded write");
    endtask

    task automatic t_same_frame;  // R9
        set_wd(18'h1_B202, 2'b00, 2'b00, 2'b00, 2'b00);
        frame(1'b1, 4'd5, 1'b1, 4'd5);
        frame(1'b1, 4'd5, 1'b0, 4'd1);
        idle(2);
        check_upto("R9 same-frame write hidden");
    endtask

    task automatic t_lanes;  // R4
        set_wd(18'h2_C303, 2'b00, 2'b00, 2'b00, 2'b00);
        frame(1'b0, 4'd0, 1'b1, 4'd7);
        set_wd(18'h0_0D44, 2'b01, 2'b10, 2'b11, 2'b00);
        frame(1'b0, 4'd0, 1'b1, 4'd7);
        frame(1'b1, 4'd7, 1'b0, 4'd0);
        idle(2);
        frame(1'b1, 4'd7, 1'b0, 4'd0);
        idle(2);
        check_upto("R4 lane enables");
    endtask

    task automatic t_deselect;  // R8
        set_wd(18'h3_FFFF, 2'b00, 2'b00, 2'b00, 2'b00);
        frame(1'b0, 4'd7, 1'b0, 4'd7);
        frame(1'b0, 4'd7, 1'b0, 4'd7);
        idle(1);
        frame(1'b1, 4'd7, 1'b0, 4'd7);
        idle(3);
        check_upto("R8 deselected ports");
    endtask

    task automatic t_extended;  // R6, R10
        lat_ext = 1'b1;
        set_wd(18'h1_2E55, 2'b00, 2'b00, 2'b00, 2'b00);
        frame(1'b0, 4'd0, 1'b1, 4'd9);
        frame(1'b1, 4'd9, 1'b0, 4'd0);
        frame(1'b1, 4'd7, 1'b0, 4'd0);
        set_wd(18'h0_5F66, 2'b00, 2'b10, 2'b00, 2'b01);
        frame(1'b1, 4'd9, 1'b1, 4'd9);
        frame(1'b1, 4'd9, 1'b0, 4'd0);
        idle(3);
        check_upto("R6/R10 extended latency");
        lat_ext = 1'b0;
    endtask

    task automatic t_stream;  // R5, R10
        set_wd(18'h2_6077, 2'b00, 2'b00, 2'b00, 2'b00);
        frame(1'b1, 4'd5, 1'b1, 4'd2);
        frame(1'b1, 4'd2, 1'b0, 4'd0);
        frame(1'b1, 4'd7, 1'b0, 4'd0);
        frame(1'b1, 4'd9, 1'b0, 4'd0);
        idle(2);
        check_upto("R5/R10 legacy stream");
    endtask

    task automatic t_top_addr;  // R3
        set_wd(18'h3_7188, 2'b00, 2'b00, 2'b00, 2'b00);
        frame(1'b0, 4'd0, 1'b1, 4'd15);
        idle(1);
        frame(1'b1, 4'd15, 1'b0, 4'd0);
        frame(1'b1, 4'd0, 1'b0, 4'd0);
        frame(1'b1, 4'd14, 1'b0, 4'd0);
        idle(2);
        check_upto("R3 top address no alias");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < MAXE; e++) begin exp_v[e] = 1'b0; exp_d[e] = '0; end
        for (int w = 0; w < WORDS; w++) mdl[w] = '0;
        carry_d[0] = 18'h2_AAAA; carry_d[1] = 18'h1_5555;
        carry_b[0] = '0; carry_b[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_unwritten();
        t_forward();
        t_same_frame();
        t_lanes();
        t_deselect();
        t_extended();
        t_stream();
        t_top_addr();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule